// File: doc/BRIEF.md
# Checked Clock-Phase Sequencer

This block generates a repeating three-phase timing sequence for an I/O channel. A request from idle launches a sequence that walks through phase A0, then phase A1, then a step phase. Every phase lasts a fixed number of system clocks, set by a parameter. A two-bit timing pair marks where the sequence stands, and counters take the place of analogue delay elements. A second two-bit pair keeps its own record of which phases have actually been entered.

The block compares the two pairs on every cycle. It also checks that the record pair moves only through its allowed progression. Any mismatch or out-of-order move latches a fault. The fault freezes the sequencer in place until reset, so a damaged clock sequence can never keep driving the channel. A re-start request made at any point during a sequence chains the next sequence directly after the step phase, with no idle gap between them.

Both latch pairs are brought out on ports, so the surrounding logic can see the sequencer's position. The phase strobes are the outputs that clock the rest of the channel.

Top module: `clkseq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, all phase strobes are 0, `seq_done` is 0, `fault` is 0, `stopped` is 1, and both `tim_cd` and `chk_ab` read 2'b00.
- R2: A `start` sampled high while idle begins phase A0 at the next clock edge. A0, A1 and step then follow in that order, each lasting exactly PHASE_LEN cycles.
- R3: At most one of `ph_a0`, `ph_a1`, `ph_step` is high in any cycle.
- R4: `seq_done` is high for exactly the one cycle after a step phase ends. If no re-start is pending, that cycle is idle: no strobe is high and `stopped` is 1. `stopped` is 0 while a phase is running.
- R5: A `restart` sampled high on any cycle of a running sequence, including the last step cycle, makes A0 begin on the cycle right after the step phase ends.
- R6: `start` while a sequence runs has no effect on its timing and does not chain a new sequence. `restart` while idle starts nothing and is not remembered.
- R7: The record pair `chk_ab` ({A,B}) reads 00 when idle, 10 in A0, 11 in A1 and 01 in step. Its only legal moves are 00→10, 10→11, 11→01, 01→00 and 01→10. Any other move sets `fault`.
- R8: If `chk_ab` and `tim_cd` disagree, `fault` is set on the next clock edge. Agreement means: 00 with 00, 10 with 10, 11 with 00, and 01 with 01 or 11.
- R9: `fault` is sticky until reset. Once it is set, the strobes, `tim_cd` and `chk_ab` hold their values, `start` and `restart` are ignored, `seq_done` is 0 and `stopped` is 1.
- R10: Reset clears `fault`, and a sequence started after reset runs normally.
- R11: The timing pair `tim_cd` ({C,D}) reads 10 in A0 and 00 in A1 or idle. In step it reads 01, or 11 once a re-start is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sequence from idle |
| restart | input | 1 | Request a chained sequence after the current step phase |
| ph_a0 | output | 1 | Phase A0 strobe |
| ph_a1 | output | 1 | Phase A1 strobe |
| ph_step | output | 1 | Step phase strobe |
| seq_done | output | 1 | One-cycle pulse after each step phase |
| stopped | output | 1 | No sequence running (idle or halted by a fault) |
| fault | output | 1 | Sticky sequencing fault |
| tim_cd | output | 2 | Timing pair {C,D} |
| chk_ab | output | 2 | Record pair {A,B} |

## Verification
The bench runs a lone sequence as the baseline. It then sweeps the re-start pulse across every cycle of a sequence, which separates chaining from returning to idle and finds where the pending re-start first shows on the timing pair. It also sweeps a stray `start` across every cycle to confirm it leaves the timing untouched. A re-start pulse while idle shows that nothing is remembered. Forcing the record pair to a wrong value during A1 separates a correct halt, where the outputs freeze and stay frozen, from a sequencer that runs on.

// File: rtl/phseq_pkg.sv
package phseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_A0   = 2'd1,
        PH_A1   = 2'd2,
        PH_STEP = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_A0   = 3'd1,
        EV_A1   = 3'd2,
        EV_STEP = 3'd3,
        EV_IDLE = 3'd4
    } event_e;

    typedef struct packed {
        logic c;
        logic d;
    } tim_pair_t;

    typedef struct packed {
        logic a;
        logic b;
    } chk_pair_t;

    // timing pair code for the phase being entered
    function automatic tim_pair_t tim_code(input phase_e ph, input logic pend);
        tim_pair_t r;
        case (ph)
            PH_A0:   r = '{c: 1'b1, d: 1'b0};
            PH_STEP: r = '{c: pend, d: 1'b1};
            default: r = '{c: 1'b0, d: 1'b0};
        endcase
        return r;
    endfunction

    // record pair value after a phase-entry event
    function automatic chk_pair_t chk_after(input event_e ev, input chk_pair_t cur);
        chk_pair_t r;
        case (ev)
            EV_A0:   r = '{a: 1'b1, b: 1'b0};
            EV_A1:   r = '{a: 1'b1, b: 1'b1};
            EV_STEP: r = '{a: 1'b0, b: 1'b1};
            EV_IDLE: r = '{a: 1'b0, b: 1'b0};
            default: r = cur;
        endcase
        return r;
    endfunction

    // whether an event is allowed from the current record value
    function automatic logic chk_legal(input event_e ev, input chk_pair_t cur);
        logic ok;
        case (ev)
            EV_A0:   ok = (cur == 2'b00) || (cur == 2'b01);
            EV_A1:   ok = (cur == 2'b10);
            EV_STEP: ok = (cur == 2'b11);
            EV_IDLE: ok = (cur == 2'b01);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

    // whether record and timing pairs describe the same phase
    function automatic logic pair_agree(input chk_pair_t ab, input tim_pair_t cd);
        logic ok;
        case (ab)
            2'b10:   ok = (cd == 2'b10);
            2'b11:   ok = (cd == 2'b00);
            2'b01:   ok = cd.d;
            default: ok = (cd == 2'b00);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int PHASE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic run,
    output logic last
);
    localparam int CW = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
    localparam logic [CW-1:0] TOP = CW'(PHASE_LEN - 1);

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!hold) begin
            if (!run || last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seq_core.sv
module seq_core
    import phseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  logic      start,
    input  logic      restart,
    input  logic      last,
    output phase_e    phase,
    output tim_pair_t cd,
    output event_e    ev,
    output logic      done
);
    phase_e    phase_q, phase_n;
    logic      pend_q, pend_n;
    tim_pair_t cd_q;
    logic      done_q;

    always_comb begin
        phase_n = phase_q;
        pend_n  = pend_q;
        ev      = EV_NONE;
        if (!hold) begin
            case (phase_q)
                PH_IDLE: begin
                    pend_n = 1'b0;
                    if (start) begin
                        phase_n = PH_A0;
                        ev      = EV_A0;
                    end
                end
                PH_A0: begin
                    pend_n = pend_q | restart;
                    if (last) begin
                        phase_n = PH_A1;
                        ev      = EV_A1;
                    end
                end
                PH_A1: begin
                    pend_n = pend_q | restart;
                    if (last) begin
                        phase_n = PH_STEP;
                        ev      = EV_STEP;
                    end
                end
                default: begin
                    pend_n = pend_q | restart;
                    if (last) begin
                        if (pend_n) begin
                            phase_n = PH_A0;
                            ev      = EV_A0;
                        end else begin
                            phase_n = PH_IDLE;
                            ev      = EV_IDLE;
                        end
                        pend_n = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pend_q  <= 1'b0;
            cd_q    <= '0;
            done_q  <= 1'b0;
        end else if (hold) begin
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_n;
            pend_q  <= pend_n;
            cd_q    <= tim_code(phase_n, pend_n);
            done_q  <= (phase_q == PH_STEP) && last;
        end
    end

    assign phase = phase_q;
    assign cd    = cd_q;
    assign done  = done_q;
endmodule

// File: rtl/chk_latch.sv
module chk_latch
    import phseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  event_e    ev,
    output chk_pair_t ab,
    output logic      illegal
);
    chk_pair_t ab_q;

    assign illegal = (ev != EV_NONE) && !chk_legal(ev, ab_q);
    assign ab      = ab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_q <= '0;
        end else if (ev != EV_NONE) begin
            ab_q <= chk_after(ev, ab_q);
        end
    end
endmodule

// File: rtl/fault_mon.sv
module fault_mon
    import phseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      illegal,
    input  chk_pair_t ab,
    input  tim_pair_t cd,
    output logic      err
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (illegal || !pair_agree(ab, cd)) begin
            err_q <= 1'b1;
        end
    end

    assign err = err_q;
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
    import phseq_pkg::*;
#(
    parameter int PHASE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       restart,
    output logic       ph_a0,
    output logic       ph_a1,
    output logic       ph_step,
    output logic       seq_done,
    output logic       stopped,
    output logic       fault,
    output logic [1:0] tim_cd,
    output logic [1:0] chk_ab
);
    phase_e    phase;
    tim_pair_t cd;
    chk_pair_t ab;
    event_e    ev;
    logic      last, illegal, err, done;

    phase_timer #(.PHASE_LEN(PHASE_LEN)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .hold (err),
        .run  (phase != PH_IDLE),
        .last (last)
    );

    seq_core u_seq (
        .clk     (clk),
        .rst     (rst),
        .hold    (err),
        .start   (start),
        .restart (restart),
        .last    (last),
        .phase   (phase),
        .cd      (cd),
        .ev      (ev),
        .done    (done)
    );

    chk_latch u_chk (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .ab      (ab),
        .illegal (illegal)
    );

    fault_mon u_mon (
        .clk     (clk),
        .rst     (rst),
        .illegal (illegal),
        .ab      (ab),
        .cd      (cd),
        .err     (err)
    );

    assign ph_a0    = (phase == PH_A0);
    assign ph_a1    = (phase == PH_A1);
    assign ph_step  = (phase == PH_STEP);
    assign seq_done = done;
    assign stopped  = (phase == PH_IDLE) || err;
    assign fault    = err;
    assign tim_cd   = {cd.c, cd.d};
    assign chk_ab   = {ab.a, ab.b};
endmodule

// File: rtl/phseq_sva.sv
module phseq_sva (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       ph_a0,
    input logic       ph_a1,
    input logic       ph_step,
    input logic       seq_done,
    input logic       stopped,
    input logic       fault,
    input logic [1:0] tim_cd,
    input logic [1:0] chk_ab
);
    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_a0, ph_a1, ph_step}));

    assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (stopped && !fault && start) |=> ph_a0);

    assert_a1_after_a0_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_a1) |-> $past(ph_a0));

    assert_step_after_a1_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_step) |-> $past(ph_a1));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> ($past(ph_step) && !ph_step));

    assert_cd_a0_R11: assert property (@(posedge clk) disable iff (rst)
        ph_a0 |-> (tim_cd == 2'b10));

    assert_cd_a1_R11: assert property (@(posedge clk) disable iff (rst)
        ph_a1 |-> (tim_cd == 2'b00));

    assert_cd_step_R11: assert property (@(posedge clk) disable iff (rst)
        ph_step |-> tim_cd[0]);

    assert_detect_a0_R8: assert property (@(posedge clk) disable iff (rst)
        (!fault && chk_ab == 2'b10 && tim_cd != 2'b10) |=> fault);

    assert_detect_a1_R8: assert property (@(posedge clk) disable iff (rst)
        (!fault && chk_ab == 2'b11 && tim_cd != 2'b00) |=> fault);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        fault |=> ($stable({ph_a0, ph_a1, ph_step, tim_cd, chk_ab}) && stopped && !seq_done));
endmodule

bind clkseq_top phseq_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ph_a0    (ph_a0),
    .ph_a1    (ph_a1),
    .ph_step  (ph_step),
    .seq_done (seq_done),
    .stopped  (stopped),
    .fault    (fault),
    .tim_cd   (tim_cd),
    .chk_ab   (chk_ab)
);

// File: tb/clkseq_top_test.sv
`timescale 1ns/1ps
module clkseq_top_test;
    localparam int LEN = 3;
    localparam int K   = 3 * LEN;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, restart = 1'b0;
    logic ph_a0, ph_a1, ph_step, seq_done, stopped, fault;
    logic [1:0] tim_cd, chk_ab;

    int checks = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    clkseq_top #(.PHASE_LEN(LEN)) uut (
        .clk(clk), .rst(rst), .start(start), .restart(restart),
        .ph_a0(ph_a0), .ph_a1(ph_a1), .ph_step(ph_step),
        .seq_done(seq_done), .stopped(stopped), .fault(fault),
        .tim_cd(tim_cd), .chk_ab(chk_ab)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req, input logic exp_done);
        chk(req, "strobes", {ph_a0, ph_a1, ph_step}, 3'b000);
        chk(req, "stopped", stopped, 1'b1);
        chk(req, "done", seq_done, exp_done);
        chk(req, "tim_cd", tim_cd, 2'b00);
        chk(req, "chk_ab", chk_ab, 2'b00);
        chk(req, "fault", fault, 1'b0);
    endtask

    // rk: cycle index of a restart pulse (-1 none); sk: stray start pulse (-1 none)
    task automatic run_case(input int rk, input int sk);
        int total;
        string tag;
        total = (rk >= 0) ? 2 * K : K;
        tag = (rk >= 0) ? "R5" : ((sk >= 0) ? "R6" : "R2");
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k <= total; k++) begin
            if (k == total) begin
                chk_idle("R4", 1'b1);
            end else begin
                int idx;
                logic [2:0] es;
                logic [1:0] ecd, eab;
                idx = (k / LEN) % 3;
                es  = (idx == 0) ? 3'b100 : ((idx == 1) ? 3'b010 : 3'b001);
                eab = (idx == 0) ? 2'b10 : ((idx == 1) ? 2'b11 : 2'b01);
                if (idx == 0)      ecd = 2'b10;
                else if (idx == 1) ecd = 2'b00;
                else               ecd = (rk >= 0 && k < K && rk < k) ? 2'b11 : 2'b01;
                chk(tag, "strobes", {ph_a0, ph_a1, ph_step}, es);
                chk("R4", "done", seq_done, (k > 0 && k % K == 0));
                chk("R4", "stopped", stopped, 1'b0);
                chk("R11", "tim_cd", tim_cd, ecd);
                chk("R7", "chk_ab", chk_ab, eab);
                chk("R3", "onehot", $countones({ph_a0, ph_a1, ph_step}), 1);
            end
            restart = (k == rk);
            start   = (k == sk);
            @(negedge clk);
        end
        restart = 1'b0;
        start   = 1'b0;
        chk_idle("R4", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1", 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1", 1'b0);

        run_case(-1, -1);
        for (int rk = 0; rk < K; rk++) run_case(rk, -1);
        for (int sk = 0; sk < K; sk++) run_case(-1, sk);

        // restart while idle
        restart = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_idle("R6", 1'b0);
        end
        restart = 1'b0;
        run_case(-1, -1);

        // injected record-latch fault during A1
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (LEN) @(negedge clk);
        chk("R2", "strobes", {ph_a0, ph_a1, ph_step}, 3'b010);
        force uut.u_chk.ab_q = 2'b10;
        @(negedge clk);
        release uut.u_chk.ab_q;
        chk("R8", "fault", fault, 1'b1);
        chk("R9", "stopped", stopped, 1'b1);
        for (int i = 0; i < 20; i++) begin
            start   = (i == 2) || (i == 12);
            restart = (i == 5) || (i == 13);
            @(negedge clk);
            chk("R9", "strobes", {ph_a0, ph_a1, ph_step}, 3'b010);
            chk("R9", "fault", fault, 1'b1);
            chk("R9", "chk_ab", chk_ab, 2'b10);
            chk("R9", "tim_cd", tim_cd, 2'b00);
            chk("R9", "done", seq_done, 1'b0);
            chk("R9", "stopped", stopped, 1'b1);
        end
        start = 1'b0;
        restart = 1'b0;

        // reset recovery
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R10", 1'b0);
        run_case(-1, -1);
        run_case(K - 1, -1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule